// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block paces the instruction flow of a small microcontroller core. It counts the input clock through four repeating phases (Q1, Q2, Q3, Q4). Each group of four clocks is one instruction cycle. Within that cycle the block fetches the next instruction word from program memory while the previous word executes from the instruction register. The program counter, the fetch strobe, the instruction-register load and the data-memory read and write strobes are each tied to a fixed phase. All strobes are plain single-clock enables in the one clock domain.

The decoder, which is outside this block, reports a taken jump or call through `br_take_i` and `br_target_i`. The block samples these at the end of Q4 of a valid execute cycle. It then redirects the program counter to the target. The sequential word that was already fetched behind the branch is discarded and replaced by a no-operation slot. During that slot the flush indicator is high and no data-memory strobe is issued, so a branch costs exactly one extra instruction cycle. After reset the first execute slot is also a flushed slot, so nothing executes before the first real fetch.

Top module: `qphase_seq`

## Requirements
- R1: `phase_o` steps 0,1,2,3,0,... (0=Q1, 1=Q2, 2=Q3, 3=Q4), advancing by one on every clock outside reset.
- R2: A synchronous active-high `rst` sets `pc_o` to 0, `phase_o` to 0 (Q1), `flush_o` to 1 and `ir_o` to the no-operation word (all zeros). These values are seen on the clock after the reset edge.
- R3: `fetch_addr_o` always equals `pc_o`. `fetch_stb_o` is high exactly when `phase_o` is 3, and `instr_i` is sampled at the clock edge that ends that phase.
- R4: `pc_o` changes only at the edge ending Q4, where it becomes `pc_o`+1 (wrapping from 2^PC_W-1 to 0) unless a branch is taken. `pc_step_o` is high exactly in Q1.
- R5: At the edge ending Q4, `ir_o` takes the sampled `instr_i` unless a branch is taken. `ir_load_o` is high exactly in Q1, and `ir_o` holds its value for the rest of the cycle.
- R6: `rd_stb_o` is high exactly in Q2 and `wr_stb_o` exactly in Q4 of each cycle whose `flush_o` is 0. The two are never high together.
- R7: If `br_take_i` is 1 at the edge ending Q4 while `flush_o` is 0, the next cycle has `pc_o` equal to the sampled `br_target_i`, `ir_o` equal to the no-operation word, and `flush_o` high for all four phases.
- R8: `br_take_i` has no effect in phases Q1 to Q3, nor in Q4 of a flushed cycle. In those cases the PC still advances by one and the next cycle is not flushed.
- R9: In a flushed cycle neither `rd_stb_o` nor `wr_stb_o` is asserted, and `flush_o` stays constant across the four phases of any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one phase per period |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | IW | Word read from program memory at `fetch_addr_o` |
| br_take_i | input | 1 | Decoder reports a taken jump or call |
| br_target_i | input | PC_W | Branch destination address |
| pc_o | output | PC_W | Program counter |
| fetch_addr_o | output | PC_W | Program memory address being fetched |
| fetch_stb_o | output | 1 | Fetch capture enable (Q4) |
| pc_step_o | output | 1 | Marks the phase holding a freshly advanced PC (Q1) |
| ir_o | output | IW | Instruction register |
| ir_load_o | output | 1 | Marks the phase holding a freshly loaded IR (Q1) |
| rd_stb_o | output | 1 | Data-memory operand read enable (Q2, valid slot) |
| wr_stb_o | output | 1 | Data-memory destination write enable (Q4, valid slot) |
| flush_o | output | 1 | Current execute slot is a discarded no-operation |
| phase_o | output | 2 | Current phase, 0..3 for Q1..Q4 |

## Verification
A long run with no branch shows the steady one-per-cycle pipeline, and it also shows the counter wrapping at the top of the address space. Holding `br_take_i` high on every clock tells apart a block that honours branch requests only in Q4 of a valid slot from one that also takes them in other phases or inside flushed slots. A pseudo-random mix of branch requests and targets checks that back-to-back branches alternate with flushed slots. A fixed branch to the highest address shows the flushed slot followed by a wrap to zero. A reset applied in mid-cycle confirms that the sequence restarts in Q1 with a flushed slot.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    localparam int unsigned NUM_PHASES = 4;

endpackage

// File: rtl/qseq_phase.sv
module qseq_phase
    import qseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e ph_o,
    output logic   last_o
);

    typedef struct packed {
        phase_e ph;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ph = phase_e'(s_q.ph + 2'd1);
        if (rst) begin
            s_d.ph = PH_Q1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign ph_o   = s_q.ph;
    assign last_o = (s_q.ph == PH_Q4);

endmodule

// File: rtl/qseq_pc.sv
module qseq_pc #(
    parameter int unsigned PC_W = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_i,
    input  logic            redirect_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] pc_o
);

    localparam logic [PC_W-1:0] PC_ONE   = PC_W'(1);
    localparam logic [PC_W-1:0] PC_RESET = '0;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (adv_i) begin
            if (redirect_i) begin
                s_d.pc = target_i;
            end else begin
                s_d.pc = s_q.pc + PC_ONE;
            end
        end
        if (rst) begin
            s_d.pc = PC_RESET;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign pc_o = s_q.pc;

endmodule

// File: rtl/qseq_pipe.sv
module qseq_pipe #(
    parameter int unsigned     IW       = 12,
    parameter logic [IW-1:0]   NOP_WORD = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    input  logic          squash_i,
    input  logic [IW-1:0] instr_i,
    output logic [IW-1:0] ir_o,
    output logic          flush_o
);

    typedef struct packed {
        logic [IW-1:0] ir;
        logic          flush;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (adv_i) begin
            s_d.flush = squash_i;
            s_d.ir    = squash_i ? NOP_WORD : instr_i;
        end
        if (rst) begin
            s_d.flush = 1'b1;
            s_d.ir    = NOP_WORD;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign ir_o    = s_q.ir;
    assign flush_o = s_q.flush;

endmodule

// File: rtl/qseq_strobe.sv
module qseq_strobe
    import qseq_pkg::*;
(
    input  phase_e ph_i,
    input  logic   flush_i,
    output logic   fetch_stb_o,
    output logic   pc_step_o,
    output logic   ir_load_o,
    output logic   rd_stb_o,
    output logic   wr_stb_o
);

    logic [NUM_PHASES-1:0] ph_hot;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PHASES; gi++) begin : g_hot
            assign ph_hot[gi] = (ph_i == phase_e'(gi));
        end
    endgenerate

    assign pc_step_o   = ph_hot[PH_Q1];
    assign ir_load_o   = ph_hot[PH_Q1];
    assign fetch_stb_o = ph_hot[PH_Q4];
    assign rd_stb_o    = ph_hot[PH_Q2] & ~flush_i;
    assign wr_stb_o    = ph_hot[PH_Q4] & ~flush_i;

endmodule

// File: rtl/qphase_seq.sv
module qphase_seq
    import qseq_pkg::*;
#(
    parameter int unsigned   PC_W     = 9,
    parameter int unsigned   IW       = 12,
    parameter logic [IW-1:0] NOP_WORD = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IW-1:0]   instr_i,
    input  logic            br_take_i,
    input  logic [PC_W-1:0] br_target_i,
    output logic [PC_W-1:0] pc_o,
    output logic [PC_W-1:0] fetch_addr_o,
    output logic            fetch_stb_o,
    output logic            pc_step_o,
    output logic [IW-1:0]   ir_o,
    output logic            ir_load_o,
    output logic            rd_stb_o,
    output logic            wr_stb_o,
    output logic            flush_o,
    output logic [1:0]      phase_o
);

    phase_e ph;
    logic   cycle_end;
    logic   redirect;
    logic   flush;

    qseq_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .ph_o   (ph),
        .last_o (cycle_end)
    );

    // A branch counts only when it comes from a valid (unflushed) slot.
    assign redirect = cycle_end & br_take_i & ~flush;

    qseq_pc #(
        .PC_W (PC_W)
    ) u_pc (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (cycle_end),
        .redirect_i (redirect),
        .target_i   (br_target_i),
        .pc_o       (pc_o)
    );

    qseq_pipe #(
        .IW       (IW),
        .NOP_WORD (NOP_WORD)
    ) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .adv_i    (cycle_end),
        .squash_i (redirect),
        .instr_i  (instr_i),
        .ir_o     (ir_o),
        .flush_o  (flush)
    );

    qseq_strobe u_strobe (
        .ph_i        (ph),
        .flush_i     (flush),
        .fetch_stb_o (fetch_stb_o),
        .pc_step_o   (pc_step_o),
        .ir_load_o   (ir_load_o),
        .rd_stb_o    (rd_stb_o),
        .wr_stb_o    (wr_stb_o)
    );

    assign fetch_addr_o = pc_o;
    assign flush_o      = flush;
    assign phase_o      = ph;

endmodule

// File: rtl/qphase_seq_chk.sv
module qphase_seq_chk #(
    parameter int unsigned   PC_W     = 9,
    parameter int unsigned   IW       = 12,
    parameter logic [IW-1:0] NOP_WORD = '0
) (
    input logic            clk,
    input logic            rst,
    input logic [IW-1:0]   instr_i,
    input logic            br_take_i,
    input logic [PC_W-1:0] br_target_i,
    input logic [PC_W-1:0] pc_o,
    input logic [PC_W-1:0] fetch_addr_o,
    input logic            fetch_stb_o,
    input logic            pc_step_o,
    input logic [IW-1:0]   ir_o,
    input logic            ir_load_o,
    input logic            rd_stb_o,
    input logic            wr_stb_o,
    input logic            flush_o,
    input logic [1:0]      phase_o
);

    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> phase_o == ($past(phase_o) + 2'd1));

    assert_reset_state_R2: assert property (@(posedge clk)
        rst |=> (pc_o == '0) && (phase_o == 2'd0) && flush_o && (ir_o == NOP_WORD));

    assert_fetch_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr_o == pc_o) && (fetch_stb_o == (phase_o == 2'd3)));

    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_o != 2'd0) |-> $stable(pc_o) && $stable(ir_o));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd3 && !(br_take_i && !flush_o)) |=> pc_o == ($past(pc_o) + PC_ONE));

    assert_ir_load_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd3 && !(br_take_i && !flush_o)) |=> ir_o == $past(instr_i));

    assert_q1_marks_R5: assert property (@(posedge clk) disable iff (rst)
        (pc_step_o || ir_load_o) |-> phase_o == 2'd0);

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stb_o, wr_stb_o}) && (!rd_stb_o || phase_o == 2'd1)
        && (!wr_stb_o || phase_o == 2'd3));

    assert_branch_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd3 && br_take_i && !flush_o)
        |=> (pc_o == $past(br_target_i)) && flush_o && (ir_o == NOP_WORD));

    assert_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd3 && !(br_take_i && !flush_o)) |=> !flush_o);

    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> !rd_stb_o && !wr_stb_o);

    assert_flush_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_o != 2'd0) |-> $stable(flush_o));

endmodule

bind qphase_seq qphase_seq_chk #(
    .PC_W     (PC_W),
    .IW       (IW),
    .NOP_WORD (NOP_WORD)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_i      (instr_i),
    .br_take_i    (br_take_i),
    .br_target_i  (br_target_i),
    .pc_o         (pc_o),
    .fetch_addr_o (fetch_addr_o),
    .fetch_stb_o  (fetch_stb_o),
    .pc_step_o    (pc_step_o),
    .ir_o         (ir_o),
    .ir_load_o    (ir_load_o),
    .rd_stb_o     (rd_stb_o),
    .wr_stb_o     (wr_stb_o),
    .flush_o      (flush_o),
    .phase_o      (phase_o)
);

// File: tb/sim_qphase_seq.sv
module sim_qphase_seq;

    localparam int PC_W = 9;
    localparam int IW   = 12;
    localparam int PC_MOD = 1 << PC_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [IW-1:0]   instr;
    logic            br_take = 1'b0;
    logic [PC_W-1:0] br_target = '0;
    logic [PC_W-1:0] pc, fetch_addr;
    logic            fetch_stb, pc_step, ir_load, rd_stb, wr_stb, flush;
    logic [IW-1:0]   ir;
    logic [1:0]      phase;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [IW-1:0] mem(input int a);
        return IW'((a * 37 + 5) ^ (a << 7));
    endfunction

    assign instr = mem(int'(fetch_addr));

    qphase_seq #(.PC_W(PC_W), .IW(IW)) u0 (
        .clk          (clk),
        .rst          (rst),
        .instr_i      (instr),
        .br_take_i    (br_take),
        .br_target_i  (br_target),
        .pc_o         (pc),
        .fetch_addr_o (fetch_addr),
        .fetch_stb_o  (fetch_stb),
        .pc_step_o    (pc_step),
        .ir_o         (ir),
        .ir_load_o    (ir_load),
        .rd_stb_o     (rd_stb),
        .wr_stb_o     (wr_stb),
        .flush_o      (flush),
        .phase_o      (phase)
    );

    // Behavioural reference: four-clock cycles, one-slot branch penalty.
    int m_ph = 0, m_pc = 0, m_ir = 0;
    bit m_flush = 1'b1;
    bit m_rst_seen = 1'b0;
    bit m_after_rst = 1'b0;
    bit m_took = 1'b0;
    bit m_ignored = 1'b0;
    bit m_started = 1'b0;

    always @(posedge clk) begin
        m_started = 1'b1;
        if (rst) begin
            m_ph = 0; m_pc = 0; m_ir = 0; m_flush = 1'b1;
            m_after_rst = 1'b1; m_took = 1'b0; m_ignored = 1'b0;
        end else begin
            m_after_rst = 1'b0;
            if (br_take && !(m_ph == 3 && !m_flush)) m_ignored = 1'b1;
            if (m_ph == 3) begin
                if (br_take && !m_flush) begin
                    m_ir = 0; m_pc = int'(br_target); m_flush = 1'b1;
                    m_took = 1'b1; m_ignored = 1'b0;
                end else begin
                    m_ir = int'(mem(m_pc)); m_pc = (m_pc + 1) % PC_MOD;
                    m_flush = 1'b0; m_took = 1'b0;
                end
                m_ph = 0;
            end else begin
                m_ph = m_ph + 1;
                if (m_ph == 1) m_ignored = m_ignored && 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (m_started && !done) begin
            if (m_after_rst) begin
                chk("R2", "pc after reset", int'(pc), 0);
                chk("R2", "phase after reset", int'(phase), 0);
                chk("R2", "flush after reset", int'(flush), 1);
                chk("R2", "ir after reset", int'(ir), 0);
            end else begin
                chk("R1", "phase", int'(phase), m_ph);
                chk("R3", "fetch_addr", int'(fetch_addr), m_pc);
                chk("R3", "fetch_stb", int'(fetch_stb), int'(m_ph == 3));
                if (m_took)
                    chk("R7", "pc after branch", int'(pc), m_pc);
                else if (m_ignored)
                    chk("R8", "pc with ignored branch", int'(pc), m_pc);
                else
                    chk("R4", "pc", int'(pc), m_pc);
                chk("R4", "pc_step", int'(pc_step), int'(m_ph == 0));
                chk("R5", "ir", int'(ir), m_ir);
                chk("R5", "ir_load", int'(ir_load), int'(m_ph == 0));
                if (m_took)
                    chk("R7", "flush", int'(flush), int'(m_flush));
                else
                    chk("R8", "flush", int'(flush), int'(m_flush));
                if (m_flush) begin
                    chk("R9", "rd_stb in flush", int'(rd_stb), 0);
                    chk("R9", "wr_stb in flush", int'(wr_stb), 0);
                end else begin
                    chk("R6", "rd_stb", int'(rd_stb), int'(m_ph == 1));
                    chk("R6", "wr_stb", int'(wr_stb), int'(m_ph == 3));
                end
            end
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    task automatic run(input int mode, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: begin br_take = 1'b0; br_target = '0; end
                1: begin br_take = 1'b1; br_target = lfsr[PC_W-1:0]; end
                2: begin br_take = lfsr[0] & lfsr[3]; br_target = lfsr[PC_W+2:3]; end
                default: begin br_take = 1'b1; br_target = '1; end
            endcase
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run(0, 4 * 600);      // sequential flow, wraps the 9-bit PC
        run(1, 4 * 40);       // request on every clock
        run(2, 4 * 300);      // random mix
        run(3, 4 * 20);       // branch to top address, then wrap
        run(0, 6);
        @(negedge clk);
        rst = 1'b1;           // reset in mid-cycle
        @(negedge clk);
        rst = 1'b0;
        run(2, 4 * 100);
        run(0, 8);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule